// File: doc/BRIEF.md
# Automatic RTS/CTS Handshake Controller

This block is the automatic modem handshake logic for one serial channel. On the receive side it watches the fill count of the receive FIFO. It raises an active-high stop request on `rtsN` when the count climbs past a programmable high-water level. It drops that request only after software has drained the FIFO below a separate low-water level. Between the two levels the last decision is kept, which gives the output hysteresis. When automatic RTS is switched off, the pin simply mirrors a software modem-control bit.

On the transmit side the block brings the far end's `ctsN` pin through a synchronizer. It produces `txGo`, a permit that the serializer consults before it launches a new start bit. The permit is only re-evaluated while the serializer reports that it sits at a character boundary (`txIdle`). A frame already being shifted out therefore always completes, and a stalled transmitter resumes as soon as the peer signals readiness again. The receive and transmit functions have separate enables.

Top module: `hs_flow_top`

## Requirements
- R1: After reset, `rtsN` is 0 (can receive) when automatic RTS is enabled, and `txGo` is 1.
- R2: With `autoRtsEn`=1, a `rxCount` strictly greater than `upperLvl` makes `rtsN` 1 (stop) after the next rising clock edge. A count equal to `upperLvl` does not.
- R3: With `autoRtsEn`=1, a `rxCount` strictly below `lowerLvl` (and not above `upperLvl`) makes `rtsN` 0 after the next rising edge.
- R4: With `autoRtsEn`=1 and `lowerLvl` <= `rxCount` <= `upperLvl`, `rtsN` keeps its previous value.
- R5: With `autoRtsEn`=0, `rtsN` equals the inverse of `swReady` without a clock delay, and `rxCount` has no effect. The hysteresis state is cleared, so re-enabling inside the band yields `rtsN`=0.
- R6: With `autoCtsEn`=1 and `txIdle`=1, a 0 on `ctsN` (peer not ready) clears `txGo` on the third rising edge after the change.
- R7: With `autoCtsEn`=1 and `txIdle`=1, a return of `ctsN` to 1 sets `txGo` again on the third rising edge.
- R8: While `txIdle`=0 (a character is in flight), `txGo` holds its value whatever `ctsN` does.
- R9: With `autoCtsEn`=0, `txGo` becomes 1 at the next edge on which `txIdle`=1, regardless of `ctsN`.
- R10: If the thresholds overlap so that `rxCount` is both above `upperLvl` and below `lowerLvl`, the stop request wins and `rtsN` becomes 1.
- R11: `ctsN` passes through a two-stage synchronizer. A change is not visible on `txGo` after only one or two rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxCount | input | CNT_W | Current receive FIFO fill count |
| upperLvl | input | CNT_W | High-water level; exceeding it requests stop |
| lowerLvl | input | CNT_W | Low-water level; falling under it releases stop |
| autoRtsEn | input | 1 | Enable automatic RTS hysteresis |
| autoCtsEn | input | 1 | Enable automatic CTS gating |
| swReady | input | 1 | Software modem bit; 1 drives `rtsN` to 0 when automatic RTS is off |
| ctsN | input | 1 | Peer handshake pin, asynchronous; 0 means the peer cannot accept data |
| txIdle | input | 1 | Serializer is at a character boundary, before a new start bit |
| rtsN | output | 1 | Handshake pin to the peer; 1 means stop sending |
| txGo | output | 1 | Permit to start the next transmit character |

## Verification
The bench targets the exact threshold edges. A count equal to the high-water level must not raise stop, and a count equal to the low-water level must not release it. A design using `>=` or `<=` would toggle one count early. It walks the count back through the band to catch a design without hysteresis, which would release stop as soon as the count fell below the upper level. It also drives overlapping thresholds, where a wrong priority would let the release win. On the transmit side it counts the edges from a `ctsN` change to `txGo`, which exposes a missing or extra synchronizer stage. It toggles `ctsN` while `txIdle` is low, so a design that cut off a frame in flight would drop the permit mid-character. Finally, it toggles the enables to confirm that re-enabling RTS starts in the can-receive state and that disabled CTS gating ignores the pin.

// File: rtl/hs_flow_pkg.sv
package hs_flow_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic setStop;   // force the receive stop state on
    logic clrStop;   // release the receive stop state
    logic txLoad;    // character boundary: reload the transmit permit
    logic txVal;     // value to load into the permit
  } hsStrobe_t;
endpackage

// File: rtl/hs_flow_ctrl.sv
module hs_flow_ctrl
  import hs_flow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      autoRtsEn,
  input  logic      autoCtsEn,
  input  logic      ctsN,
  input  logic      txIdle,
  input  logic      aboveUpper,
  input  logic      belowLower,
  output hsStrobe_t strb
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncQ;
  logic          ctsSync;

  // Synchronizer chain, reset to "peer ready" so no spurious stall
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[LAST-1:0], ctsN};
  end
  assign ctsSync = syncQ[LAST];

  always_comb begin
    strb.setStop = autoRtsEn & aboveUpper;               // stop wins on overlap
    strb.clrStop = ~autoRtsEn | (belowLower & ~aboveUpper);
    strb.txLoad  = txIdle;
    strb.txVal   = ~autoCtsEn | ctsSync;
  end

  // R11: two stages minimum between pin and use
  initial begin
    assert_sync_depth_R11: assert (SYNC_STAGES >= 2);
  end

  // R10: overlap never issues both strobes
  assert_no_conflict_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.setStop && strb.clrStop));
endmodule

// File: rtl/hs_flow_dp.sv
module hs_flow_dp
  import hs_flow_pkg::*;
#(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] upperLvl,
  input  logic [CNT_W-1:0] lowerLvl,
  input  logic             autoRtsEn,
  input  logic             swReady,
  input  hsStrobe_t        strb,
  output logic             aboveUpper,
  output logic             belowLower,
  output logic             rtsN,
  output logic             txGo
);
  logic rxStop;

  assign aboveUpper = rxCount > upperLvl;
  assign belowLower = rxCount < lowerLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxStop <= 1'b0;
    else if (strb.setStop) rxStop <= 1'b1;
    else if (strb.clrStop) rxStop <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            txGo <= 1'b1;
    else if (strb.txLoad) txGo <= strb.txVal;
  end

  assign rtsN = autoRtsEn ? rxStop : ~swReady;

  assert_stop_on_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    autoRtsEn && aboveUpper |=> rxStop);

  assert_release_on_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    autoRtsEn && belowLower && !aboveUpper |=> !rxStop);

  assert_hold_in_band_R4: assert property (@(posedge clk) disable iff (!rstN)
    autoRtsEn && !aboveUpper && !belowLower |=> $stable(rxStop));

  assert_clear_when_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    !autoRtsEn |=> !rxStop);

  assert_frame_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.txLoad |=> $stable(txGo));
endmodule

// File: rtl/hs_flow_top.sv
module hs_flow_top
  import hs_flow_pkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] rxCount,
  input  logic [CNT_W-1:0] upperLvl,
  input  logic [CNT_W-1:0] lowerLvl,
  input  logic             autoRtsEn,
  input  logic             autoCtsEn,
  input  logic             swReady,
  input  logic             ctsN,
  input  logic             txIdle,
  output logic             rtsN,
  output logic             txGo
);
  hsStrobe_t strb;
  logic      aboveUpper;
  logic      belowLower;

  hs_flow_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .autoRtsEn  (autoRtsEn),
    .autoCtsEn  (autoCtsEn),
    .ctsN       (ctsN),
    .txIdle     (txIdle),
    .aboveUpper (aboveUpper),
    .belowLower (belowLower),
    .strb       (strb)
  );

  hs_flow_dp #(.CNT_W(CNT_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .rxCount    (rxCount),
    .upperLvl   (upperLvl),
    .lowerLvl   (lowerLvl),
    .autoRtsEn  (autoRtsEn),
    .swReady    (swReady),
    .strb       (strb),
    .aboveUpper (aboveUpper),
    .belowLower (belowLower),
    .rtsN       (rtsN),
    .txGo       (txGo)
  );
endmodule

// File: tb/hs_flow_top_tb_top.sv
module hs_flow_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 9;
  localparam int MAX_CYC    = 200000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] rxCount = '0;
  logic [CNT_W-1:0] upperLvl = 9'd200;
  logic [CNT_W-1:0] lowerLvl = 9'd100;
  logic             autoRtsEn = 1'b1;
  logic             autoCtsEn = 1'b1;
  logic             swReady = 1'b0;
  logic             ctsN = 1'b1;
  logic             txIdle = 1'b1;
  logic             rtsN;
  logic             txGo;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference state, built from the requirements
  logic mStop, mMeta, mSync, mGo;

  hs_flow_top #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .rxCount(rxCount), .upperLvl(upperLvl),
    .lowerLvl(lowerLvl), .autoRtsEn(autoRtsEn), .autoCtsEn(autoCtsEn),
    .swReady(swReady), .ctsN(ctsN), .txIdle(txIdle), .rtsN(rtsN), .txGo(txGo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic nextStop(logic cur, logic en, int cnt, int up, int lo);
    if (!en)      return 1'b0;
    if (cnt > up) return 1'b1;   // R2, R10
    if (cnt < lo) return 1'b0;   // R3
    return cur;                  // R4
  endfunction

  function automatic logic expRts(logic st, logic en, logic sw);
    return en ? st : ~sw;        // R5
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStop = 1'b0; mMeta = 1'b1; mSync = 1'b1; mGo = 1'b1;
    end else begin
      mStop = nextStop(mStop, autoRtsEn, int'(rxCount), int'(upperLvl), int'(lowerLvl));
      if (txIdle) mGo = ~autoCtsEn | mSync;
      mSync = mMeta;
      mMeta = ctsN;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYC);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    step(3);
    rstN = 1'b1;
    step(1);
    chk("R1 rtsN after reset", rtsN, 1'b0);
    chk("R1 txGo after reset", txGo, 1'b1);

    // Receive hysteresis at the exact edges
    rxCount = 9'd200; step(1); chk("R4 equal upper no stop", rtsN, 1'b0);
    rxCount = 9'd201; step(1); chk("R2 above upper", rtsN, 1'b1);
    rxCount = 9'd150; step(1); chk("R4 hold in band", rtsN, 1'b1);
    rxCount = 9'd100; step(1); chk("R4 equal lower keeps stop", rtsN, 1'b1);
    rxCount = 9'd99;  step(1); chk("R3 below lower", rtsN, 1'b0);
    rxCount = 9'd150; step(1); chk("R4 band after release", rtsN, 1'b0);
    rxCount = 9'd256; step(1); chk("R2 full count", rtsN, 1'b1);

    // Software control
    autoRtsEn = 1'b0; swReady = 1'b1; #1;
    chk("R5 sw ready direct", rtsN, 1'b0);
    swReady = 1'b0; #1;
    chk("R5 sw not ready direct", rtsN, 1'b1);
    swReady = 1'b1; rxCount = 9'd250; step(1);
    chk("R5 count ignored", rtsN, 1'b0);
    rxCount = 9'd150; step(1);
    autoRtsEn = 1'b1; #1;
    chk("R5 reenable starts clear", rtsN, 1'b0);
    step(1); chk("R5 reenable in band", rtsN, 1'b0);

    // Overlapping thresholds
    upperLvl = 9'd50; lowerLvl = 9'd100; rxCount = 9'd70; step(1);
    chk("R10 overlap stop wins", rtsN, 1'b1);
    upperLvl = 9'd200; rxCount = 9'd0; step(1);
    chk("R3 release after overlap", rtsN, 1'b0);

    // CTS gating and synchronizer latency
    txIdle = 1'b1; ctsN = 1'b0;
    step(1); chk("R11 one edge", txGo, 1'b1);
    step(1); chk("R11 two edges", txGo, 1'b1);
    step(1); chk("R6 suspend", txGo, 1'b0);
    ctsN = 1'b1;
    step(2); chk("R11 resume latency", txGo, 1'b0);
    step(1); chk("R7 resume", txGo, 1'b1);

    // Frame in flight
    txIdle = 1'b0; ctsN = 1'b0; step(5);
    chk("R8 frame completes", txGo, 1'b1);
    txIdle = 1'b1; step(1); chk("R6 boundary stall", txGo, 1'b0);
    txIdle = 1'b0; ctsN = 1'b1; step(5);
    chk("R8 held low in frame", txGo, 1'b0);
    txIdle = 1'b1; step(1); chk("R7 boundary resume", txGo, 1'b1);

    // CTS gating disabled
    ctsN = 1'b0; step(3); chk("R6 stalled again", txGo, 1'b0);
    autoCtsEn = 1'b0; step(1); chk("R9 disabled permits", txGo, 1'b1);
    step(4); chk("R9 pin ignored", txGo, 1'b1);

    // Random phase against the reference
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 5) begin
        upperLvl = 9'($urandom_range(0, 256));
        lowerLvl = 9'($urandom_range(0, 256));
      end
      if ($urandom_range(0, 3) == 0) rxCount = 9'($urandom_range(0, 256));
      else if ($urandom_range(0, 1) == 1 && rxCount < 9'd256) rxCount = rxCount + 9'd1;
      else if (rxCount > 0) rxCount = rxCount - 9'd1;
      if ($urandom_range(0, 49) == 0) autoRtsEn = ~autoRtsEn;
      if ($urandom_range(0, 49) == 0) autoCtsEn = ~autoCtsEn;
      if ($urandom_range(0, 9) == 0)  swReady = ~swReady;
      if ($urandom_range(0, 7) == 0)  ctsN = ~ctsN;
      if ($urandom_range(0, 5) == 0)  txIdle = ~txIdle;
      step(1);
      chk("R4 random rtsN model", rtsN, expRts(mStop, autoRtsEn, swReady));
      chk("R8 random txGo model", txGo, mGo);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule